// File: doc/BRIEF.md
# Real-Time Clock Event Status and Interrupt Unit

This unit sits beside the calendar core of a real-time clock. It collects that core's event signals: one-cycle rollover strobes for seconds, minutes, hours and days, an alarm-match pulse, and a level that shows the clock is running. It keeps them in a status register of sticky flags. A power-up flag is raised by reset and stays raised until software acknowledges it. Software clears any flag by writing a one to its bit.

A configuration register enables two interrupt sources. The first is a periodic timer, whose period is picked from the four rollover flags by a 2-bit selector. The second is the alarm. The unit drives a single level-sensitive interrupt line built from the enabled flags. The line stays high until software clears the flag behind it. A handler reads the status register, tests the alarm bit first, and treats a clear alarm bit as a periodic update.

Software reaches both registers through a byte-wide register port. Writes are single-cycle strobes, and read data is a combinational function of the address.

Top module: `rtc_event_ctrl`

## Requirements
- R1: After reset the status register (address 0x0E) reads 0x80 with the running bit equal to `core_run_i`, the configuration register (address 0x0F) reads 0x00, and `irq_o` is low.
- R2: A one-cycle strobe on the second, minute, hour or day rollover input sets status bit 2, 3, 4 or 5 respectively, and the flag stays set after the strobe ends.
- R3: A pulse on `alarm_match_i` sets status bit 6, which stays set after the pulse ends.
- R4: A write to 0x0E clears every flag in bits 2 to 7 whose data bit is 1 and leaves every flag whose data bit is 0 unchanged.
- R5: If an event arrives in the same cycle as a write-1 clear of its own flag, the flag is set after that cycle.
- R6: The power-up flag (status bit 7) is set only by reset; once cleared by a write of 1 it stays clear whatever events arrive.
- R7: Status bit 1 reads the current value of `core_run_i`, status bit 0 reads 0, and writes to either bit have no effect.
- R8: Address 0x0F holds the period selector in bits 1:0, the timer enable in bit 2 and the alarm enable in bit 3; bits 7:4 read as 0 whatever was written.
- R9: `irq_o` equals (alarm flag AND alarm enable) OR (selected period flag AND timer enable), where selector 00 picks the second flag, 01 the minute flag, 10 the hour flag and 11 the day flag; the other rollover flags have no effect on `irq_o`.
- R10: With the alarm enabled, `irq_o` stays high for as long as the alarm flag is set and falls in the cycle after the flag is cleared.
- R11: Addresses other than 0x0E and 0x0F read as 0x00, and writes to them change neither register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| core_run_i | input | 1 | Running state of the calendar core |
| alarm_match_i | input | 1 | Alarm-match pulse from the calendar core |
| tick_sec_i | input | 1 | Seconds rollover strobe |
| tick_min_i | input | 1 | Minutes rollover strobe |
| tick_hour_i | input | 1 | Hours rollover strobe |
| tick_day_i | input | 1 | Days rollover strobe |
| reg_addr_i | input | ADDR_W (8) | Register address |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | DATA_W (8) | Write data |
| reg_rdata_o | output | DATA_W (8) | Read data for `reg_addr_i` |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench goes after several corner cases.

- **Event in the same cycle as its clear.** A design that lets the clear win would lose that event.
- **The period selector, walked through all four codes with the non-selected flags set.** A wrong mux mapping would raise the interrupt from the wrong rollover.
- **A write of 1 to the power-up bit, then to the run bit.** A design that reset the power-up flag on events would set it again. One that stored the run bit would stop following the core.
- **A long wait with the alarm pending.** A pulsed interrupt instead of a held level would drop the line there.
- **Writes to unmapped addresses and to the unused configuration bits.** Decoding that is too wide would corrupt the real registers on these writes.

// File: rtl/rtc_evt_pkg.sv
package rtc_evt_pkg;

   // flag indices inside the sticky flag vector
   localparam int unsigned EVT_SEC   = 0;
   localparam int unsigned EVT_MIN   = 1;
   localparam int unsigned EVT_HOUR  = 2;
   localparam int unsigned EVT_DAY   = 3;
   localparam int unsigned EVT_ALARM = 4;
   localparam int unsigned EVT_PWRUP = 5;
   localparam int unsigned N_FLAGS   = 6;
   localparam int unsigned N_PERIODS = 4;

   // status register layout: flag i sits at bit STAT_FLAG_LSB + i
   localparam int unsigned STAT_RUN_BIT  = 1;
   localparam int unsigned STAT_FLAG_LSB = 2;

   // configuration register layout
   localparam int unsigned CFG_TIMER_EN_BIT = 2;
   localparam int unsigned CFG_ALARM_EN_BIT = 3;
   localparam int unsigned CFG_BITS         = 4;

   typedef enum logic [1:0] {
      PER_SEC  = 2'b00,
      PER_MIN  = 2'b01,
      PER_HOUR = 2'b10,
      PER_DAY  = 2'b11
   } period_e;

   typedef struct packed {
      logic    alarm_en;
      logic    timer_en;
      period_e period;
   } irq_cfg_t;

endpackage

// File: rtl/rtc_evt_flagbank.sv
// Bank of sticky flags: set by an event, cleared by a write-1 strobe.
// An event in the same cycle as the clear keeps the flag set.
module rtc_evt_flagbank #(
   parameter int unsigned       N       = 6,
   parameter logic [N-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] q_o
);

   if (N == 0) begin : g_bad_n
      $error("rtc_evt_flagbank: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q <= RST_VAL[i];
         end else if (set_i[i]) begin
            q <= 1'b1;
         end else if (clr_i[i]) begin
            q <= 1'b0;
         end
      end
      assign q_o[i] = q;
   end

endmodule

// File: rtl/rtc_evt_cfg.sv
// Interrupt configuration register: period selector and two enables.
module rtc_evt_cfg
   import rtc_evt_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [CFG_BITS-1:0] wdata_i,
   output irq_cfg_t            cfg_o
);

   irq_cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_i) begin
         cfg_q.period   <= period_e'(wdata_i[1:0]);
         cfg_q.timer_en <= wdata_i[CFG_TIMER_EN_BIT];
         cfg_q.alarm_en <= wdata_i[CFG_ALARM_EN_BIT];
      end
   end

   assign cfg_o = cfg_q;

endmodule

// File: rtl/rtc_evt_irqgen.sv
// Combines the enabled flags into the level interrupt request.
module rtc_evt_irqgen
   import rtc_evt_pkg::*;
(
   input  logic [N_PERIODS-1:0] period_flags_i,
   input  logic                 alarm_flag_i,
   input  irq_cfg_t             cfg_i,
   output logic                 irq_o
);

   logic sel_flag;
   logic timer_req;
   logic alarm_req;

   always_comb begin
      unique case (cfg_i.period)
         PER_SEC:  sel_flag = period_flags_i[EVT_SEC];
         PER_MIN:  sel_flag = period_flags_i[EVT_MIN];
         PER_HOUR: sel_flag = period_flags_i[EVT_HOUR];
         PER_DAY:  sel_flag = period_flags_i[EVT_DAY];
         default:  sel_flag = 1'b0;
      endcase
   end

   assign timer_req = sel_flag & cfg_i.timer_en;
   assign alarm_req = alarm_flag_i & cfg_i.alarm_en;
   assign irq_o     = timer_req | alarm_req;

endmodule

// File: rtl/rtc_event_ctrl.sv
// Status and interrupt unit of the real-time clock: top level.
module rtc_event_ctrl
   import rtc_evt_pkg::*;
#(
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned STATUS_ADDR = 'h0E,
   parameter int unsigned CFG_ADDR    = 'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_run_i,
   input  logic              alarm_match_i,
   input  logic              tick_sec_i,
   input  logic              tick_min_i,
   input  logic              tick_hour_i,
   input  logic              tick_day_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_we_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic              irq_o
);

   localparam int unsigned STAT_TOP = STAT_FLAG_LSB + N_FLAGS;
   localparam logic [N_FLAGS-1:0] FLAG_RST = N_FLAGS'(1) << EVT_PWRUP;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STATUS_ADDR);
   localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(CFG_ADDR);

   // elaboration-time parameter checks
   if (DATA_W < STAT_TOP) begin : g_bad_data_w
      $error("rtc_event_ctrl: DATA_W too narrow for the status register");
   end
   if (STATUS_ADDR >= (1 << ADDR_W) || CFG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr_w
      $error("rtc_event_ctrl: register address does not fit ADDR_W");
   end
   if (STATUS_ADDR == CFG_ADDR) begin : g_addr_clash
      $error("rtc_event_ctrl: register addresses must differ");
   end

   // address decode
   logic sel_status;
   logic sel_cfg;
   logic wr_status;
   logic wr_cfg;

   assign sel_status = (reg_addr_i == A_STAT);
   assign sel_cfg    = (reg_addr_i == A_CFG);
   assign wr_status  = reg_we_i & sel_status;
   assign wr_cfg     = reg_we_i & sel_cfg;

   // sticky flags
   logic [N_FLAGS-1:0] flag_set;
   logic [N_FLAGS-1:0] flag_clr;
   logic [N_FLAGS-1:0] flag_q;

   always_comb begin
      flag_set            = '0;
      flag_set[EVT_SEC]   = tick_sec_i;
      flag_set[EVT_MIN]   = tick_min_i;
      flag_set[EVT_HOUR]  = tick_hour_i;
      flag_set[EVT_DAY]   = tick_day_i;
      flag_set[EVT_ALARM] = alarm_match_i;
      flag_set[EVT_PWRUP] = 1'b0;
   end

   assign flag_clr = wr_status ? reg_wdata_i[STAT_TOP-1:STAT_FLAG_LSB] : '0;

   rtc_evt_flagbank #(
      .N       (N_FLAGS),
      .RST_VAL (FLAG_RST)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (flag_set),
      .clr_i (flag_clr),
      .q_o   (flag_q)
   );

   // configuration register
   irq_cfg_t cfg_q;

   rtc_evt_cfg u_cfg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (wr_cfg),
      .wdata_i (reg_wdata_i[CFG_BITS-1:0]),
      .cfg_o   (cfg_q)
   );

   // interrupt request
   rtc_evt_irqgen u_irq (
      .period_flags_i (flag_q[N_PERIODS-1:0]),
      .alarm_flag_i   (flag_q[EVT_ALARM]),
      .cfg_i          (cfg_q),
      .irq_o          (irq_o)
   );

   // read path
   always_comb begin
      reg_rdata_o = '0;
      if (sel_status) begin
         reg_rdata_o[STAT_RUN_BIT]                = core_run_i;
         reg_rdata_o[STAT_TOP-1:STAT_FLAG_LSB]    = flag_q;
      end else if (sel_cfg) begin
         reg_rdata_o[1:0]                         = cfg_q.period;
         reg_rdata_o[CFG_TIMER_EN_BIT]            = cfg_q.timer_en;
         reg_rdata_o[CFG_ALARM_EN_BIT]            = cfg_q.alarm_en;
      end
   end

endmodule

// File: rtl/rtc_event_ctrl_chk.sv
// Property checker bound to rtc_event_ctrl.
module rtc_event_ctrl_chk
   import rtc_evt_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick_sec_i,
   input logic               alarm_match_i,
   input logic               wr_status,
   input logic [DATA_W-1:0]  reg_wdata_i,
   input logic [N_FLAGS-1:0] flag_q,
   input irq_cfg_t           cfg_q,
   input logic               irq_o
);

   localparam int unsigned SEC_BIT = STAT_FLAG_LSB + EVT_SEC;

   // R2: a seconds strobe leaves its flag set
   p_sec_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tick_sec_i |=> flag_q[EVT_SEC]);

   // R3: an alarm match leaves the alarm flag set
   p_alarm_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_match_i |=> flag_q[EVT_ALARM]);

   // R4: a write of 1 with no competing event clears the flag
   p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && reg_wdata_i[SEC_BIT] && !tick_sec_i) |=> !flag_q[EVT_SEC]);

   // R5: event and clear in the same cycle leave the flag set
   p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_status && reg_wdata_i[SEC_BIT] && tick_sec_i) |=> flag_q[EVT_SEC]);

   // R6: once cleared, the power-up flag never comes back without reset
   p_pwrup_stays_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !flag_q[EVT_PWRUP] |=> !flag_q[EVT_PWRUP]);

   // R10: an enabled, pending alarm holds the request high
   p_alarm_holds_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[EVT_ALARM] && cfg_q.alarm_en) |-> irq_o);

   // R9: the request has a source among the enabled flags
   p_irq_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ((flag_q[EVT_ALARM] && cfg_q.alarm_en) ||
                 (cfg_q.timer_en && (|flag_q[N_PERIODS-1:0]))));

endmodule

bind rtc_event_ctrl rtc_event_ctrl_chk #(
   .DATA_W (DATA_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tick_sec_i    (tick_sec_i),
   .alarm_match_i (alarm_match_i),
   .wr_status     (wr_status),
   .reg_wdata_i   (reg_wdata_i),
   .flag_q        (flag_q),
   .cfg_q         (cfg_q),
   .irq_o         (irq_o)
);

// File: tb/rtc_event_ctrl_test.sv
`timescale 1ns/1ps
module rtc_event_ctrl_test;

   localparam logic [7:0] A_STAT = 8'h0E;
   localparam logic [7:0] A_CFG  = 8'h0F;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       core_run = 1'b0;
   logic       alarm_match = 1'b0;
   logic       t_sec = 1'b0;
   logic       t_min = 1'b0;
   logic       t_hour = 1'b0;
   logic       t_day = 1'b0;
   logic [7:0] addr = 8'h00;
   logic       we = 1'b0;
   logic [7:0] wdata = 8'h00;
   logic [7:0] rdata;
   logic       irq;

   int checks = 0;
   int failures = 0;

   always #2.5 clk = ~clk;

   rtc_event_ctrl uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .core_run_i    (core_run),
      .alarm_match_i (alarm_match),
      .tick_sec_i    (t_sec),
      .tick_min_i    (t_min),
      .tick_hour_i   (t_hour),
      .tick_day_i    (t_day),
      .reg_addr_i    (addr),
      .reg_we_i      (we),
      .reg_wdata_i   (wdata),
      .reg_rdata_o   (rdata),
      .irq_o         (irq)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [7:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a;
      #1;
      d = rdata;
   endtask

   // ev bits: 0 sec, 1 min, 2 hour, 3 day, 4 alarm; optional write in same cycle
   task automatic cycle(input logic [4:0] ev, input logic do_wr,
                        input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      t_sec = ev[0]; t_min = ev[1]; t_hour = ev[2]; t_day = ev[3];
      alarm_match = ev[4];
      we = do_wr; addr = a; wdata = d;
      @(negedge clk);
      t_sec = 1'b0; t_min = 1'b0; t_hour = 1'b0; t_day = 1'b0;
      alarm_match = 1'b0; we = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      cycle(5'b0, 1'b1, a, d);
   endtask

   task automatic pulse(input logic [4:0] ev);
      cycle(ev, 1'b0, 8'h00, 8'h00);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_reset_state();
      logic [7:0] d;
      do_reset();
      rd(A_STAT, d); chk("R1 status after reset", d, 8'h80);
      rd(A_CFG, d);  chk("R1 cfg after reset", d, 8'h00);
      chk("R1 irq after reset", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_rollovers();
      logic [7:0] d;
      wr(A_STAT, 8'hFC);
      for (int i = 0; i < 4; i++) begin
         pulse(5'(1 << i));
         repeat (2) @(negedge clk);
         rd(A_STAT, d);
         chk("R2 rollover flag sticky", d & 8'h3C, 8'((4'b1 << i) - 1 + (1 << i)) << 2);
      end
   endtask

   task automatic t_alarm_flag();
      logic [7:0] d;
      wr(A_STAT, 8'hFC);
      pulse(5'b10000);
      repeat (3) @(negedge clk);
      rd(A_STAT, d); chk("R3 alarm flag sticky", d, 8'h40);
   endtask

   task automatic t_w1c();
      logic [7:0] d;
      pulse(5'b11111);
      wr(A_STAT, 8'h28); // clears sec(bit3? no) -> bits 3 and 5
      rd(A_STAT, d); chk("R4 partial clear", d, 8'h54);
      wr(A_STAT, 8'h00);
      rd(A_STAT, d); chk("R4 zero write keeps flags", d, 8'h54);
      wr(A_STAT, 8'hFC);
      rd(A_STAT, d); chk("R4 full clear", d, 8'h00);
   endtask

   task automatic t_set_wins();
      logic [7:0] d;
      pulse(5'b00001);
      cycle(5'b00001, 1'b1, A_STAT, 8'h04);
      rd(A_STAT, d); chk("R5 sec event beats clear", d, 8'h04);
      cycle(5'b10000, 1'b1, A_STAT, 8'h40);
      rd(A_STAT, d); chk("R5 alarm event beats clear", d, 8'h44);
      wr(A_STAT, 8'hFC);
   endtask

   task automatic t_powerup();
      logic [7:0] d;
      do_reset();
      pulse(5'b11111);
      wr(A_STAT, 8'h7C);
      rd(A_STAT, d); chk("R6 power-up survives other clears", d, 8'h80);
      wr(A_STAT, 8'h80);
      rd(A_STAT, d); chk("R6 power-up cleared by write 1", d, 8'h00);
      pulse(5'b11111);
      wr(A_STAT, 8'h7C);
      rd(A_STAT, d); chk("R6 power-up not set by events", d, 8'h00);
      do_reset();
      rd(A_STAT, d); chk("R6 power-up set again by reset", d, 8'h80);
      wr(A_STAT, 8'h80);
   endtask

   task automatic t_run_bit();
      logic [7:0] d;
      core_run = 1'b1;
      rd(A_STAT, d); chk("R7 run bit follows core high", d, 8'h02);
      wr(A_STAT, 8'h03);
      rd(A_STAT, d); chk("R7 write to run bit ignored", d, 8'h02);
      core_run = 1'b0;
      rd(A_STAT, d); chk("R7 run bit follows core low", d, 8'h00);
      wr(A_STAT, 8'h03);
      rd(A_STAT, d); chk("R7 write does not set run bit", d, 8'h00);
   endtask

   task automatic t_cfg();
      logic [7:0] d;
      wr(A_CFG, 8'hFF);
      rd(A_CFG, d); chk("R8 cfg upper bits read 0", d, 8'h0F);
      wr(A_CFG, 8'h06);
      rd(A_CFG, d); chk("R8 cfg field write", d, 8'h06);
      wr(A_CFG, 8'h00);
      rd(A_CFG, d); chk("R8 cfg cleared", d, 8'h00);
   endtask

   task automatic t_period_sel();
      logic [7:0] d;
      for (int p = 0; p < 4; p++) begin
         wr(A_STAT, 8'hFC);
         wr(A_CFG, 8'(4 | p));
         pulse(5'(4'hF & ~(4'b1 << p)));
         rd(A_STAT, d);
         chk("R9 other periods do not interrupt", {7'b0, irq}, 8'h00);
         pulse(5'(1 << p));
         rd(A_STAT, d);
         chk("R9 selected period interrupts", {7'b0, irq}, 8'h01);
         wr(A_CFG, 8'(p));
         rd(A_STAT, d);
         chk("R9 timer disabled masks request", {7'b0, irq}, 8'h00);
      end
      wr(A_CFG, 8'h00);
      wr(A_STAT, 8'hFC);
   endtask

   task automatic t_alarm_hold();
      logic [7:0] d;
      wr(A_CFG, 8'h00);
      pulse(5'b10000);
      rd(A_STAT, d);
      chk("R9 disabled alarm gives no request", {7'b0, irq}, 8'h00);
      wr(A_CFG, 8'h08);
      rd(A_STAT, d);
      chk("R10 enabled pending alarm requests", {7'b0, irq}, 8'h01);
      repeat (20) @(negedge clk);
      rd(A_STAT, d);
      chk("R10 request held while flag set", {7'b0, irq}, 8'h01);
      chk("R10 handler sees alarm bit", d & 8'h40, 8'h40);
      wr(A_STAT, 8'h40);
      rd(A_STAT, d);
      chk("R10 request drops after clear", {7'b0, irq}, 8'h00);
      wr(A_CFG, 8'h00);
   endtask

   task automatic t_unmapped();
      logic [7:0] d;
      wr(A_CFG, 8'h05);
      pulse(5'b00010);
      wr(8'h00, 8'hFF);
      wr(8'h10, 8'hFF);
      wr(8'h0D, 8'hFF);
      rd(A_STAT, d); chk("R11 status untouched by stray writes", d, 8'h08);
      rd(A_CFG, d);  chk("R11 cfg untouched by stray writes", d, 8'h05);
      rd(8'h00, d);  chk("R11 unmapped reads 0", d, 8'h00);
      rd(8'h10, d);  chk("R11 unmapped high reads 0", d, 8'h00);
      wr(A_STAT, 8'hFC);
      wr(A_CFG, 8'h00);
   endtask

   initial begin
      t_reset_state();
      t_rollovers();
      t_alarm_flag();
      t_w1c();
      t_set_wins();
      t_powerup();
      t_run_bit();
      t_cfg();
      t_period_sel();
      t_alarm_hold();
      t_unmapped();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule